// File: doc/BRIEF.md
# CAN Bus-Off and Error-Threshold Supervisor

This block sits beside the error counters of a CAN node and decides whether the node may take part in bus traffic. It compares the transmit and receive error counts against a warning threshold, takes the node off the bus when the transmit count hits its limit, and walks the node back through a long recessive-bit recovery before handing it to a host-controlled initialization state.

Recovery is counted in strobes from the bit-timing logic. Each strobe carries one sampled bit. The node first needs 128 runs of 11 consecutive recessive bits. It then needs one more power-up run of 11 recessive bits. After that it raises a one-cycle pulse that clears the error counters, and it parks in software initialization. Traffic is enabled only once the host writes the initialization bit to 0. Host writes are ignored for as long as the node is off the bus.

Top module: `can_busoff_supervisor`

## Requirements
- R1: After reset, swinit_o is 1, and bus_off_o, msg_en_o and cnt_clr_o are 0.
- R2: When not bus-off and tec_i is 256 or more at a clock edge, then after that edge bus_off_o is 1 and swinit_o is 0.
- R3: While bus_off_o is 1, msg_en_o is 0.
- R4: Recovery counts strobes (bit_stb_i=1) with bit_rec_i=1 as recessive and bit_rec_i=0 as dominant. It needs 128 runs of 11 consecutive recessive strobes, then a further run of 11. A dominant strobe restarts only the run in progress, never the count of completed runs. After the edge of the final recessive strobe, bus_off_o is 0 and swinit_o is 1.
- R5: cnt_clr_o is 1 for exactly the one cycle after the edge that ends recovery, and 0 otherwise.
- R6: While not bus-off, a host write (host_wr_i=1) loads host_wdata_i into swinit_o at the next edge. msg_en_o is 1 exactly when both swinit_o and bus_off_o are 0.
- R7: Host writes while bus_off_o is 1 have no effect on swinit_o, on msg_en_o or on recovery.
- R8: With thr_mode_i=0, warn_o is 1 when tec_i or rec_i exceeds 96, and 0 when both are 96 or less.
- R9: With thr_mode_i=1, warn_o is 1 when tec_i or rec_i is 128 or more, and 0 when both are below 128.
- R10: rec_i alone never causes bus-off, even at 256 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_i | input | 9 | Transmit error count |
| rec_i | input | 9 | Receive error count |
| bit_stb_i | input | 1 | One sampled bus bit is valid this cycle |
| bit_rec_i | input | 1 | Sampled bit is recessive (1) or dominant (0) |
| thr_mode_i | input | 1 | Warning threshold select: 0 for above 96, 1 for 128 or more |
| host_wr_i | input | 1 | Host write strobe for the initialization bit |
| host_wdata_i | input | 1 | Value written to the initialization bit |
| bus_off_o | output | 1 | Node is off the bus |
| warn_o | output | 1 | Error-count warning flag |
| swinit_o | output | 1 | Software initialization bit |
| cnt_clr_o | output | 1 | One-cycle pulse that clears both error counters |
| msg_en_o | output | 1 | Message transmit and receive enabled |

## Verification
The assertions assume that the external counter logic lowers tec_i below 256 once bus-off has been entered, or at the latest in response to cnt_clr_o. If it did not, the node would fall straight back into bus-off after recovery. They also assume that bit_stb_i carries at most one bit per clock. The stimulus drops tec_i to zero one cycle after each bus-off entry and drives strobes as single-cycle pulses at the negative edge. It keeps a raised tec_i of 256 or more only for the cycle in which entry is tested.

// File: rtl/can_sup_pkg.sv
package can_sup_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_BUSOFF  = 2'd1,
    ST_POWERUP = 2'd2,
    ST_SWINIT  = 2'd3
  } sup_state_e;
endpackage

// File: rtl/can_seq_cnt.sv
// Counts inc_i events up to LIMIT, pulses done_o on the last one and wraps.
module can_seq_cnt #(
  parameter int LIMIT = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = inc_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (inc_i)     cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/can_warn_cmp.sv
module can_warn_cmp #(
  parameter int CNT_W   = 9,
  parameter int WARN_LO = 96,
  parameter int WARN_HI = 128
) (
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             thr_mode_i,
  output logic             warn_o
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(WARN_LO);
  localparam logic [CNT_W-1:0] HI = CNT_W'(WARN_HI);

  logic warn_lo, warn_hi;
  assign warn_lo = (tec_i > LO) || (rec_i > LO);
  assign warn_hi = (tec_i >= HI) || (rec_i >= HI);
  assign warn_o  = thr_mode_i ? warn_hi : warn_lo;

  always_comb begin
    if (!thr_mode_i && tec_i <= LO && rec_i <= LO)
      p_warn_quiet_r8: assert (!warn_o);
  end
endmodule

// File: rtl/can_busoff_supervisor.sv
module can_busoff_supervisor
  import can_sup_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int BUSOFF_LIM = 256,
  parameter int RUN_LEN    = 11,
  parameter int RUN_COUNT  = 128,
  parameter int WARN_LO    = 96,
  parameter int WARN_HI    = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             bit_stb_i,
  input  logic             bit_rec_i,
  input  logic             thr_mode_i,
  input  logic             host_wr_i,
  input  logic             host_wdata_i,
  output logic             bus_off_o,
  output logic             warn_o,
  output logic             swinit_o,
  output logic             cnt_clr_o,
  output logic             msg_en_o
);
  localparam logic [CNT_W:0] LIM = (CNT_W+1)'(BUSOFF_LIM);

  sup_state_e state_q, state_d;
  logic       cnt_clr_q;
  logic       run_active, run_done, blk_done, tec_limit;

  assign run_active = (state_q == ST_BUSOFF) || (state_q == ST_POWERUP);
  assign tec_limit  = {1'b0, tec_i} >= LIM;

  can_seq_cnt #(.LIMIT(RUN_LEN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!run_active),
    .inc_i     (bit_stb_i && bit_rec_i),
    .restart_i (bit_stb_i && !bit_rec_i),
    .done_o    (run_done)
  );

  // Completed runs survive dominant bits; only leaving BUSOFF clears them.
  can_seq_cnt #(.LIMIT(RUN_COUNT)) u_blk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q != ST_BUSOFF),
    .inc_i     (run_done),
    .restart_i (1'b0),
    .done_o    (blk_done)
  );

  can_warn_cmp #(.CNT_W(CNT_W), .WARN_LO(WARN_LO), .WARN_HI(WARN_HI)) u_warn (
    .tec_i      (tec_i),
    .rec_i      (rec_i),
    .thr_mode_i (thr_mode_i),
    .warn_o     (warn_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE, ST_SWINIT: begin
        if (tec_limit)      state_d = ST_BUSOFF;
        else if (host_wr_i) state_d = host_wdata_i ? ST_SWINIT : ST_ACTIVE;
      end
      ST_BUSOFF:  if (blk_done) state_d = ST_POWERUP;
      ST_POWERUP: if (run_done) state_d = ST_SWINIT;
      default:    state_d = ST_SWINIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SWINIT;
      cnt_clr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_clr_q <= (state_q == ST_POWERUP) && run_done;
    end
  end

  assign bus_off_o = run_active;
  assign swinit_o  = (state_q == ST_SWINIT);
  assign msg_en_o  = (state_q == ST_ACTIVE);
  assign cnt_clr_o = cnt_clr_q;

  p_busoff_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_off_o && tec_limit) |=> (bus_off_o && !swinit_o));
  p_no_msg_busoff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> !msg_en_o);
  p_exit_swinit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> (swinit_o && cnt_clr_o));
  p_clr_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |=> !cnt_clr_o);
  p_msg_needs_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_en_o |-> !swinit_o);
  p_swinit_low_busoff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> !swinit_o);
endmodule

// File: tb/tb_can_busoff_supervisor.sv
module tb_can_busoff_supervisor;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] tec_i = '0, rec_i = '0;
  logic       bit_stb_i = 1'b0, bit_rec_i = 1'b0, thr_mode_i = 1'b0;
  logic       host_wr_i = 1'b0, host_wdata_i = 1'b0;
  logic       bus_off_o, warn_o, swinit_o, cnt_clr_o, msg_en_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  can_busoff_supervisor dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(input int n, input logic r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      bit_stb_i = 1'b1;
      bit_rec_i = r;
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    bit_stb_i = 1'b0;
    host_wr_i = 1'b0;
  endtask

  task automatic host_write(input logic v);
    @(negedge clk_i);
    host_wr_i = 1'b1;
    host_wdata_i = v;
    @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 swinit", swinit_o, 1'b1);
    chk("R1 bus_off", bus_off_o, 1'b0);
    chk("R1 msg_en", msg_en_o, 1'b0);
    chk("R1 cnt_clr", cnt_clr_o, 1'b0);
  endtask

  task automatic t_host();
    host_write(1'b0);
    chk("R6 swinit cleared", swinit_o, 1'b0);
    chk("R6 msg_en", msg_en_o, 1'b1);
    host_write(1'b1);
    chk("R6 swinit set", swinit_o, 1'b1);
    chk("R6 msg_en off", msg_en_o, 1'b0);
    host_write(1'b0);
  endtask

  task automatic t_warn();
    @(negedge clk_i);
    thr_mode_i = 1'b0; tec_i = 9'd96; rec_i = 9'd96; #1;
    chk("R8 both 96", warn_o, 1'b0);
    rec_i = 9'd97; #1;
    chk("R8 rec 97", warn_o, 1'b1);
    rec_i = 9'd0; tec_i = 9'd97; #1;
    chk("R8 tec 97", warn_o, 1'b1);
    thr_mode_i = 1'b1; #1;
    chk("R9 tec 97", warn_o, 1'b0);
    tec_i = 9'd127; rec_i = 9'd127; #1;
    chk("R9 both 127", warn_o, 1'b0);
    rec_i = 9'd128; #1;
    chk("R9 rec 128", warn_o, 1'b1);
    thr_mode_i = 1'b0; tec_i = 9'd0; rec_i = 9'd0;
  endtask

  task automatic t_rec_only();
    @(negedge clk_i);
    rec_i = 9'd300;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 bus_off", bus_off_o, 1'b0);
    chk("R10 msg_en", msg_en_o, 1'b1);
    rec_i = 9'd0;
  endtask

  task automatic t_enter();
    @(negedge clk_i);
    tec_i = 9'd255;
    @(negedge clk_i);
    chk("R2 below limit", bus_off_o, 1'b0);
    tec_i = 9'd256;
    @(negedge clk_i);
    chk("R2 bus_off", bus_off_o, 1'b1);
    chk("R2 swinit", swinit_o, 1'b0);
    chk("R3 msg_en", msg_en_o, 1'b0);
    tec_i = 9'd0;
  endtask

  task automatic t_blocked();
    host_write(1'b1);
    chk("R7 swinit after write 1", swinit_o, 1'b0);
    chk("R7 still bus_off", bus_off_o, 1'b1);
    host_write(1'b0);
    chk("R7 msg_en after write 0", msg_en_o, 1'b0);
  endtask

  task automatic t_recover();
    send(22, 1'b1);       // two full runs
    send(3, 1'b1);
    send(1, 1'b0);        // dominant: restart run only
    send(126 * 11, 1'b1); // completes 128 runs
    send(10, 1'b1);
    send(1, 1'b0);        // dominant during power-up run
    send(10, 1'b1);
    idle();
    chk("R4 not yet", bus_off_o, 1'b1);
    chk("R5 no pulse early", cnt_clr_o, 1'b0);
    send(1, 1'b1);
    idle();
    chk("R4 bus_off cleared", bus_off_o, 1'b0);
    chk("R4 swinit set", swinit_o, 1'b1);
    chk("R5 cnt_clr", cnt_clr_o, 1'b1);
    chk("R3 msg_en in swinit", msg_en_o, 1'b0);
    @(negedge clk_i);
    chk("R5 pulse ends", cnt_clr_o, 1'b0);
    host_write(1'b0);
    chk("R6 release after recovery", msg_en_o, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_host();
    t_warn();
    t_rec_only();
    t_enter();
    t_blocked();
    t_recover();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule